// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a run of words between one peripheral and memory while the processor does other work. Software sets up the transfer through a small register window. It chooses which way the data flows, which device to serve, the first memory word and how many words to move. It then issues a start command. From then on the engine competes for the system bus one word at a time. It requests the bus only when the device is able to take part. It holds the bus for a single transfer cycle and then drops the request, so that the processor is delayed only at its own next bus access. No processor context switch takes place for a stolen cycle.

After each completed word, the memory pointer moves forward by one and the remaining count drops by one. When the count reaches zero, a completion flag raises the interrupt line. The line stays high until software clears the flag. A bus fault ends the run early and sets an error flag, which also drives the interrupt. A grant that is withdrawn before the cycle finishes leaves the pointer and the count unchanged, and the same word is tried again.

Top module: `cs_dma`

## Requirements
- R1: After reset, the status register (index 4: bit 0 busy, bit 1 done, bit 2 error) reads zero, and `bus_req` and `irq` are low.
- R2: While idle, writes to index 0 (bit 0 direction: 0 moves device to memory, 1 moves memory to device), index 1 (device address), index 2 (memory address) and index 3 (word count) read back at the same index.
- R3: While busy, writes to indices 0 to 3 are ignored. Reads of index 2 and index 3 keep showing the live pointer and the live count.
- R4: A start command (index 0, bit 1 set) with a count of zero sets done in the same edge, and `bus_req` never rises.
- R5: `bus_req` is high only while the engine is busy and either holds a granted cycle or sees `dev_ready` high with a nonzero count.
- R6: A transfer cycle completes when `bus_gnt` and `bus_ack` are both high. On that edge, the pointer rises by one, the count falls by one, and `dev_strobe` pulses. `bus_req` is low in the next cycle.
- R7: If `bus_gnt` falls before `bus_ack`, the pointer and the count are unchanged, and the same word is transferred on a later grant.
- R8: In a cycle the engine owns, `bus_addr` is the pointer and `bus_we` is the inverse of the direction bit. Device-to-memory transfers put `dev_rdata` on `bus_wdata`. Memory-to-device transfers present `bus_rdata` on `dev_wdata` at the strobe.
- R9: Done is set on the cycle after the last word. `irq` stays high until software writes index 4 with bit 1 set.
- R10: `bus_err` during a granted cycle ends the run. It sets the error flag and raises `irq`, and the pointer and the count are left unchanged. Writing index 4 with bit 2 set clears the error flag.
- R11: `dev_addr` always carries the programmed device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| dev_ready | input | 1 | Device can supply or accept a word |
| dev_addr | output | DEVW | Programmed device address |
| dev_rdata | input | DW | Word from the device |
| dev_wdata | output | DW | Word to the device |
| dev_strobe | output | 1 | One word moved this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_ack | input | 1 | Transfer cycle completes |
| bus_err | input | 1 | Transfer cycle faulted |
| bus_addr | output | AW | Memory word address |
| bus_we | output | 1 | Memory write cycle |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data |
| irq | output | 1 | Completion or error interrupt |

## Verification
The assertions check the following on every cycle:
- The request stays low while the engine is idle.
- The request drops in the cycle after each completed word.
- The pointer and the count step by exactly one per word.
- A withdrawn grant leaves the pointer and the count unchanged.
- The interrupt stays high until it is cleared.
- A zero-count start and a bus fault each reach their end state on the next edge.

Other behaviour shows up only in the bench's scenarios. This covers the data and address seen per word in each direction, a word retried after a lost grant, parameter writes being ignored mid-run, and the request staying low while the device is not ready.

// File: rtl/cs_dma.sv
module cs_dma #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int DEVW = 8,
  parameter int CW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            dev_ready,
  output logic [DEVW-1:0] dev_addr,
  input  logic [DW-1:0]   dev_rdata,
  output logic [DW-1:0]   dev_wdata,
  output logic            dev_strobe,
  output logic            bus_req,
  input  logic            bus_gnt,
  input  logic            bus_ack,
  input  logic            bus_err,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_we,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic            irq
);
  localparam logic [2:0] IX_CTRL = 3'd0;
  localparam logic [2:0] IX_DEV  = 3'd1;
  localparam logic [2:0] IX_MEM  = 3'd2;
  localparam logic [2:0] IX_CNT  = 3'd3;
  localparam logic [2:0] IX_STAT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_OWN, S_REL} st_t;

  st_t             st;
  logic            dir;
  logic [DEVW-1:0] dev;
  logic [AW-1:0]   maddr;
  logic [CW-1:0]   cnt;
  logic            done, err;
  logic            busy, own, wr_ok;

  assign busy       = st != S_IDLE;
  assign own        = st == S_OWN;
  assign wr_ok      = reg_we && !busy;
  assign bus_req    = (st == S_WAIT && dev_ready && cnt != '0) || own;
  assign dev_strobe = own && bus_gnt && bus_ack && !bus_err;
  assign bus_addr   = maddr;
  assign bus_we     = own && !dir;
  assign bus_wdata  = dev_rdata;
  assign dev_wdata  = bus_rdata;
  assign dev_addr   = dev;
  assign irq        = done || err;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IX_CTRL: reg_rdata = DW'(dir);
      IX_DEV:  reg_rdata = DW'(dev);
      IX_MEM:  reg_rdata = DW'(maddr);
      IX_CNT:  reg_rdata = DW'(cnt);
      IX_STAT: reg_rdata = DW'({err, done, busy});
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      dir   <= 1'b0;
      dev   <= '0;
      maddr <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          IX_CTRL: begin
            dir <= reg_wdata[0];
            if (reg_wdata[1]) begin
              if (cnt == '0) done <= 1'b1;
              else           st   <= S_WAIT;
            end
          end
          IX_DEV:  dev   <= reg_wdata[DEVW-1:0];
          IX_MEM:  maddr <= reg_wdata[AW-1:0];
          IX_CNT:  cnt   <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (reg_we && reg_addr == IX_STAT) begin
        if (reg_wdata[1]) done <= 1'b0;
        if (reg_wdata[2]) err  <= 1'b0;
      end
      case (st)
        S_WAIT: if (bus_req && bus_gnt) st <= S_OWN;
        S_OWN: begin
          if (!bus_gnt) st <= S_WAIT;
          else if (bus_err) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (bus_ack) begin
            maddr <= maddr + 1'b1;
            cnt   <= cnt - 1'b1;
            st    <= S_REL;
          end
        end
        S_REL: begin
          if (cnt == '0) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else st <= S_WAIT;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_err,
  input logic          dev_strobe,
  input logic          irq,
  input logic          busy,
  input logic          own,
  input logic          done,
  input logic          err,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] maddr
);
  p_req_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |=> !bus_req);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |=> (cnt + 1'b1 == $past(cnt)) && (maddr == $past(maddr) + 1'b1));

  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own && !bus_gnt) |=> ($stable(cnt) && $stable(maddr)));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && reg_addr == 3'd4)) |=> irq);

  p_zero_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 3'd0 && reg_wdata[1] && cnt == '0) |=> (done && !bus_req));

  p_busy_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 3'd2 && !dev_strobe) |=> $stable(maddr));

  p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (own && bus_gnt && bus_err) |=> (err && !busy && $stable(cnt)));
endmodule

bind cs_dma cs_dma_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_err(bus_err), .dev_strobe(dev_strobe), .irq(irq), .busy(busy),
  .own(own), .done(done), .err(err), .cnt(cnt), .maddr(maddr)
);

// File: tb/tb_cs_dma.sv
`timescale 1ns/1ps
module tb_cs_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        dev_ready = 1'b0;
  logic [7:0]  dev_addr;
  logic [15:0] dev_rdata, dev_wdata;
  logic        dev_strobe, bus_req, bus_we, irq;
  logic        bus_gnt = 1'b0, bus_ack = 1'b0, bus_err = 1'b0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [15:0] idx = 16'h0;

  int checks = 0;
  int fails = 0;
  bit withdraw_once = 0;
  bit err_once = 0;

  logic [15:0] cap_a[$];
  logic [15:0] cap_d[$];

  always #2 clk = ~clk;

  assign bus_rdata = bus_addr ^ 16'h5555;
  assign dev_rdata = 16'hA000 + idx;

  cs_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_ready(dev_ready),
    .dev_addr(dev_addr), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
    .dev_strobe(dev_strobe), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle, 1 waiting, 2 holding, 3 releasing
  int          m_ph;
  logic        m_dir, m_done, m_err;
  logic [7:0]  m_dev;
  logic [15:0] m_ptr;
  int          m_left;

  function automatic logic e_req();
    return (m_ph == 1 && dev_ready && m_left != 0) || m_ph == 2;
  endfunction

  function automatic logic [15:0] e_rd();
    case (reg_addr)
      3'd0: return {15'h0, m_dir};
      3'd1: return {8'h0, m_dev};
      3'd2: return m_ptr;
      3'd3: return 16'(m_left);
      3'd4: return {13'h0, m_err, m_done, m_ph != 0};
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    int  was;
    logic rq;
    if (!rst_n) begin
      m_ph = 0; m_dir = 0; m_done = 0; m_err = 0; m_dev = 0; m_ptr = 0; m_left = 0;
    end else begin
      was = m_ph;
      rq  = e_req();
      if (reg_we && was == 0) begin
        if (reg_addr == 3'd0) begin
          m_dir = reg_wdata[0];
          if (reg_wdata[1]) begin
            if (m_left == 0) m_done = 1; else m_ph = 1;
          end
        end
        if (reg_addr == 3'd1) m_dev = reg_wdata[7:0];
        if (reg_addr == 3'd2) m_ptr = reg_wdata;
        if (reg_addr == 3'd3) m_left = int'(reg_wdata[11:0]);
      end
      if (reg_we && reg_addr == 3'd4) begin
        if (reg_wdata[1]) m_done = 0;
        if (reg_wdata[2]) m_err = 0;
      end
      if (was == 1 && rq && bus_gnt) m_ph = 2;
      else if (was == 2) begin
        if (!bus_gnt) m_ph = 1;
        else if (bus_err) begin m_err = 1; m_ph = 0; end
        else if (bus_ack) begin m_ptr = m_ptr + 1; m_left = m_left - 1; m_ph = 3; end
      end else if (was == 3) begin
        if (m_left == 0) begin m_done = 1; m_ph = 0; end
        else m_ph = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 bus_req", bus_req, e_req());
      chk("R9 irq", irq, m_done || m_err);
      chk("R6 dev_strobe", dev_strobe, m_ph == 2 && bus_gnt && bus_ack && !bus_err);
      chk("R8 bus_we", bus_we, m_ph == 2 && !m_dir);
      chk("R8 bus_addr", bus_addr, m_ptr);
      chk("R11 dev_addr", dev_addr, m_dev);
      chk("R2 reg_rdata", reg_rdata, e_rd());
      if (dev_strobe) begin
        cap_a.push_back(bus_addr);
        cap_d.push_back(bus_we ? bus_wdata : dev_wdata);
        idx = idx + 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (!rst_n || !bus_req) begin
      bus_gnt = 0; bus_ack = 0; bus_err = 0;
    end else if (!bus_gnt) begin
      bus_gnt = 1; bus_ack = 0;
    end else if (withdraw_once) begin
      bus_gnt = 0; bus_ack = 0; withdraw_once = 0;
    end else if (err_once) begin
      bus_err = 1; err_once = 0;
    end else bus_ack = 1;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(3'd4, v);
    chk("R1 status after reset", v, 16'h0);
    chk("R1 bus_req after reset", bus_req, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);

    wr(3'd1, 16'h005A); wr(3'd2, 16'h0100); wr(3'd3, 16'h0003); wr(3'd0, 16'h0001);
    rd(3'd1, v); chk("R2 device address", v, 16'h005A);
    rd(3'd2, v); chk("R2 memory address", v, 16'h0100);
    rd(3'd3, v); chk("R2 count", v, 16'h0003);
    rd(3'd0, v); chk("R2 direction", v, 16'h0001);

    wr(3'd3, 16'h0000); wr(3'd0, 16'h0002);
    @(negedge clk);
    chk("R4 irq after zero start", irq, 1'b1);
    chk("R4 no request", bus_req, 1'b0);
    rd(3'd4, v); chk("R4 status done only", v, 16'h0002);
    wr(3'd4, 16'h0002);
    @(negedge clk); chk("R9 irq cleared", irq, 1'b0);

    cap_a.delete(); cap_d.delete(); idx = 0;
    wr(3'd3, 16'h0003); wr(3'd2, 16'h0100);
    dev_ready = 1;
    wr(3'd0, 16'h0002);
    wait_irq();
    chk("R6 words moved", cap_a.size(), 3);
    for (int i = 0; i < 3 && i < cap_a.size(); i++) begin
      chk("R8 device-to-memory address", cap_a[i], 16'h0100 + 16'(i));
      chk("R8 device-to-memory data", cap_d[i], 16'hA000 + 16'(i));
    end
    rd(3'd2, v); chk("R6 final pointer", v, 16'h0103);
    rd(3'd3, v); chk("R6 final count", v, 16'h0000);
    rd(3'd4, v); chk("R9 done set", v, 16'h0002);
    repeat (5) @(negedge clk);
    chk("R9 irq held", irq, 1'b1);
    wr(3'd4, 16'h0002);
    @(negedge clk); chk("R9 irq cleared after run", irq, 1'b0);

    cap_a.delete(); cap_d.delete();
    dev_ready = 0;
    wr(3'd3, 16'h0002); wr(3'd2, 16'h0200); wr(3'd0, 16'h0003);
    repeat (8) @(negedge clk);
    chk("R5 no request while device not ready", bus_req, 1'b0);
    wr(3'd2, 16'h0777); wr(3'd3, 16'h0009); wr(3'd1, 16'h0011);
    rd(3'd2, v); chk("R3 pointer locked", v, 16'h0200);
    rd(3'd3, v); chk("R3 count locked", v, 16'h0002);
    chk("R11 device address kept", dev_addr, 8'h5A);
    withdraw_once = 1;
    dev_ready = 1;
    wait_irq();
    chk("R7 words moved despite lost grant", cap_a.size(), 2);
    for (int i = 0; i < 2 && i < cap_a.size(); i++) begin
      chk("R7 retried address", cap_a[i], 16'h0200 + 16'(i));
      chk("R8 memory-to-device data", cap_d[i], (16'h0200 + 16'(i)) ^ 16'h5555);
    end
    rd(3'd2, v); chk("R7 final pointer", v, 16'h0202);
    wr(3'd4, 16'h0002);

    wr(3'd3, 16'h0004); wr(3'd2, 16'h0300);
    err_once = 1;
    wr(3'd0, 16'h0002);
    wait_irq();
    rd(3'd4, v); chk("R10 error status", v, 16'h0004);
    rd(3'd2, v); chk("R10 pointer unchanged", v, 16'h0300);
    rd(3'd3, v); chk("R10 count unchanged", v, 16'h0004);
    wr(3'd4, 16'h0004);
    @(negedge clk); chk("R10 irq cleared", irq, 1'b0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule